// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive path just after the preamble has been removed. It watches the first bytes of every incoming frame, which form the destination address, and decides whether the frame is meant for this station. Frames arrive one byte per cycle. A valid strobe qualifies each byte, and a start-of-frame strobe marks the first byte of a frame. Four accept rules can each be switched on or off on their own:
- an exact match against the programmed station address;
- the all-ones broadcast address;
- any multicast address;
- multicast addresses whose hash selects a set bit in a 64-bit table.

The station address, the hash table and the rule enables come in as plain parallel inputs. Software is expected to set them before reception starts. After the last destination byte, the block holds a decision flag, an accept flag and a code for the rule that fired until the next frame begins. Downstream logic uses these flags to keep or drop the frame. CRC checking and frame storage are done elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: When `en_ucast` is 1 and all six destination bytes equal `station_addr`, the frame is accepted with `match_type` = 1. The first byte on the wire is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`.
- R2: The all-ones destination is accepted with `match_type` = 2 when `en_bcast` is 1 and is rejected when `en_bcast` is 0. The multicast rules never accept the all-ones destination.
- R3: A destination is multicast when bit 0 of its first byte is 1. When `en_mcall` is 1, every such non-broadcast destination is accepted with `match_type` = 3.
- R4: When `en_mcall` is 0 and `en_mchash` is 1, a non-broadcast multicast destination is accepted with `match_type` = 4 only if `hash_table[idx]` is 1. The hash is a CRC-32 with polynomial 0x04C11DB7 and initial value all ones. It is run over the six bytes in wire order, with each byte fed least significant bit first. `idx` is bits 31..26 of the final register, with no final inversion.
- R5: When no enabled rule matches, `match_type` = 0 and `accept` = 0. In every other case `accept` = 1. An exact station match takes precedence over the broadcast and multicast rules.
- R6: `decision_valid` goes to 1 at the clock edge that takes the sixth destination byte. The enables, station address and hash table are sampled at that same edge.
- R7: Once set, `decision_valid`, `accept` and `match_type` hold. Bytes after the sixth, without start-of-frame, change none of them.
- R8: A byte with `byte_sof` = 1 starts a new frame, even in the middle of an address, and clears `decision_valid` at that edge. Bytes that arrive without start-of-frame while no frame has started are ignored.
- R9: After reset, `decision_valid`, `accept` and `match_type` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A byte is present on `byte_data` this cycle |
| byte_sof | input | 1 | The present byte is the first byte of a frame |
| byte_data | input | 8 | Received byte |
| station_addr | input | 48 | Own station address; bits 47:40 are the first byte on the wire |
| hash_table | input | 64 | Multicast hash table, one bit per hash index |
| en_ucast | input | 1 | Enable the exact station match rule |
| en_bcast | input | 1 | Enable the broadcast rule |
| en_mcall | input | 1 | Enable the accept-all-multicast rule |
| en_mchash | input | 1 | Enable the hashed multicast rule |
| decision_valid | output | 1 | The decision for the current frame is ready |
| accept | output | 1 | The frame is to be kept |
| match_type | output | 3 | 0 none, 1 unicast, 2 broadcast, 3 all multicast, 4 hashed multicast |

## Verification
Each byte is driven on a falling clock edge and is taken on the following rising edge. All three results are therefore due on the falling edge right after the edge that takes the sixth destination byte, and the bench compares them there against a reference model. The model computes its hash with a reflected CRC of its own. On the falling edge that presents the sixth byte, the bench also checks that `decision_valid` is still 0, which shows that the clear from start-of-frame has already taken effect. After the extra trailing bytes and the out-of-frame bytes, the bench reads the held outputs again to confirm they have not moved.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

   typedef enum logic [2:0] {
      MT_NONE   = 3'd0,
      MT_UCAST  = 3'd1,
      MT_BCAST  = 3'd2,
      MT_MCALL  = 3'd3,
      MT_MCHASH = 3'd4
   } match_t;

   localparam logic [31:0] HASH_POLY = 32'h04C11DB7;

endpackage

// File: rtl/afilt_seq.sv
// Tracks the byte position inside the destination field.
module afilt_seq #(
   parameter int ADDR_BYTES = 6,
   localparam int IDX_W = $clog2(ADDR_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             byte_sof,
   output logic             take,
   output logic             first,
   output logic             last,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] FULL     = IDX_W'(ADDR_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

   // 0: no frame open, 1..ADDR_BYTES-1: inside field, ADDR_BYTES: field done
   logic [IDX_W-1:0] pos_q;

   always_comb begin
      idx   = byte_sof ? '0 : pos_q;
      take  = byte_valid && (byte_sof || (pos_q != '0 && pos_q < FULL));
      first = take && byte_sof;
      last  = take && (idx == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (byte_valid && byte_sof)
         pos_q <= IDX_W'(1);
      else if (take)
         pos_q <= pos_q + IDX_W'(1);
   end

   // R8: position counter never runs past the end of the field
   a_r8_pos_bound : assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= FULL);

   // R7: a completed field stays complete until a new start-of-frame
   a_r7_pos_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == FULL && !(byte_valid && byte_sof)) |=> pos_q == FULL);

endmodule

// File: rtl/afilt_cmp.sv
// Accumulates exact-match, all-ones and group-bit results over the field.
module afilt_cmp #(
   parameter int DATA_W     = 8,
   parameter int ADDR_BYTES = 6,
   localparam int IDX_W  = $clog2(ADDR_BYTES + 1),
   localparam int ADDR_W = DATA_W * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              first,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] station,
   output logic              ucast_nxt,
   output logic              bcast_nxt,
   output logic              mcast_nxt,
   output logic              ucast_q,
   output logic              bcast_q,
   output logic              mcast_q
);

   logic [DATA_W-1:0] sta_byte;

   // first wire byte maps to the most significant station byte
   always_comb begin
      sta_byte = '0;
      for (int b = 0; b < ADDR_BYTES; b++)
         if (idx == IDX_W'(b))
            sta_byte = station[(ADDR_BYTES-1-b)*DATA_W +: DATA_W];
   end

   always_comb begin
      ucast_nxt = (first || ucast_q) && (data == sta_byte);
      bcast_nxt = (first || bcast_q) && (&data);
      mcast_nxt = first ? data[0] : mcast_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ucast_q <= 1'b0;
         bcast_q <= 1'b0;
         mcast_q <= 1'b0;
      end else if (take) begin
         ucast_q <= ucast_nxt;
         bcast_q <= bcast_nxt;
         mcast_q <= mcast_nxt;
      end
   end

   // R2: an all-ones field is always a group address
   a_r2_bcast_is_group : assert property (@(posedge clk) disable iff (!rst_n)
      bcast_q |-> mcast_q);

endmodule

// File: rtl/afilt_hash.sv
// Bit-serial CRC over the destination bytes, yielding the table index.
module afilt_hash #(
   parameter int DATA_W    = 8,
   parameter int HASH_BITS = 6,
   parameter bit HASH_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 first,
   input  logic [DATA_W-1:0]    data,
   output logic [HASH_BITS-1:0] hash_idx_nxt
);

   import afilt_pkg::*;

   generate
      if (HASH_EN) begin : g_crc
         logic [31:0] crc_q, crc_nxt;

         function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                                  input logic [DATA_W-1:0] d);
            logic [31:0] c;
            logic        fb;
            c = c_in;
            for (int i = 0; i < DATA_W; i++) begin
               fb = c[31] ^ d[i];
               c  = {c[30:0], 1'b0};
               if (fb) c = c ^ HASH_POLY;
            end
            return c;
         endfunction

         always_comb begin
            crc_nxt      = crc_step(first ? 32'hFFFF_FFFF : crc_q, data);
            hash_idx_nxt = crc_nxt[31 -: HASH_BITS];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               crc_q <= 32'hFFFF_FFFF;
            else if (take)
               crc_q <= crc_nxt;
         end
      end else begin : g_no_crc
         logic unused_in;
         assign unused_in    = ^{clk, rst_n, take, first, data};
         assign hash_idx_nxt = '0;
      end
   endgenerate

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int DATA_W     = 8,
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter bit HASH_EN    = 1'b1,
   localparam int ADDR_W       = DATA_W * ADDR_BYTES,
   localparam int HASH_ENTRIES = 1 << HASH_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_valid,
   input  logic                    byte_sof,
   input  logic [DATA_W-1:0]       byte_data,
   input  logic [ADDR_W-1:0]       station_addr,
   input  logic [HASH_ENTRIES-1:0] hash_table,
   input  logic                    en_ucast,
   input  logic                    en_bcast,
   input  logic                    en_mcall,
   input  logic                    en_mchash,
   output logic                    decision_valid,
   output logic                    accept,
   output logic [2:0]              match_type
);

   import afilt_pkg::*;

   localparam int IDX_W = $clog2(ADDR_BYTES + 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (ADDR_BYTES < 2) begin : g_bad_len
         $error("ADDR_BYTES must be at least 2");
      end
      if (HASH_BITS < 1 || HASH_BITS > 16) begin : g_bad_hash
         $error("HASH_BITS must lie in 1..16");
      end
   endgenerate

   logic             take, first, last;
   logic [IDX_W-1:0] idx;
   logic             ucast_nxt, bcast_nxt, mcast_nxt;
   logic             ucast_q, bcast_q, mcast_q;
   logic [HASH_BITS-1:0] hash_idx;
   logic             hash_hit;
   match_t           cls, type_q;
   logic             dec_valid_q;

   afilt_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
      .take(take), .first(first), .last(last), .idx(idx));

   afilt_cmp #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)) u_cmp (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .idx(idx),
      .data(byte_data), .station(station_addr),
      .ucast_nxt(ucast_nxt), .bcast_nxt(bcast_nxt), .mcast_nxt(mcast_nxt),
      .ucast_q(ucast_q), .bcast_q(bcast_q), .mcast_q(mcast_q));

   afilt_hash #(.DATA_W(DATA_W), .HASH_BITS(HASH_BITS), .HASH_EN(HASH_EN)) u_hash (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .data(byte_data),
      .hash_idx_nxt(hash_idx));

   assign hash_hit = HASH_EN && hash_table[hash_idx];

   // exact match first, then broadcast, then the multicast rules
   always_comb begin
      cls = MT_NONE;
      if (en_ucast && ucast_nxt)
         cls = MT_UCAST;
      else if (bcast_nxt) begin
         if (en_bcast) cls = MT_BCAST;
      end else if (mcast_nxt) begin
         if (en_mcall)
            cls = MT_MCALL;
         else if (en_mchash && hash_hit)
            cls = MT_MCHASH;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid_q <= 1'b0;
         type_q      <= MT_NONE;
      end else if (last) begin
         dec_valid_q <= 1'b1;
         type_q      <= cls;
      end else if (first) begin
         dec_valid_q <= 1'b0;
         type_q      <= MT_NONE;
      end
   end

   assign decision_valid = dec_valid_q;
   assign match_type     = type_q;
   assign accept         = (type_q != MT_NONE);

   // R6: last destination byte yields a decision on the next cycle
   a_r6_valid_after_last : assert property (@(posedge clk) disable iff (!rst_n)
      last |=> decision_valid);

   // R7: decision holds while no new frame starts
   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (decision_valid && !(byte_valid && byte_sof)) |=>
         (decision_valid && $stable(match_type)));

   // R8: start-of-frame withdraws the previous decision
   a_r8_sof_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_sof) |=> !decision_valid);

   // R2: multicast codes are never given to the all-ones address
   a_r2_bcast_priority : assert property (@(posedge clk) disable iff (!rst_n)
      (decision_valid && (type_q == MT_MCALL || type_q == MT_MCHASH)) |-> !bcast_q);

   // R3: multicast codes need the group bit of the first byte
   a_r3_group_bit : assert property (@(posedge clk) disable iff (!rst_n)
      (decision_valid && (type_q == MT_MCALL || type_q == MT_MCHASH)) |-> mcast_q);

   // R1: unicast code needs a full station match
   a_r1_ucast_match : assert property (@(posedge clk) disable iff (!rst_n)
      (decision_valid && type_q == MT_UCAST) |-> ucast_q);

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0;
   logic        byte_sof = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic [47:0] station_addr = 48'h0;
   logic [63:0] hash_table = 64'h0;
   logic        en_ucast = 1'b0, en_bcast = 1'b0, en_mcall = 1'b0, en_mchash = 1'b0;
   logic        decision_valid, accept;
   logic [2:0]  match_type;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rx_addr_filter uut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
      .byte_data(byte_data), .station_addr(station_addr), .hash_table(hash_table),
      .en_ucast(en_ucast), .en_bcast(en_bcast), .en_mcall(en_mcall),
      .en_mchash(en_mchash), .decision_valid(decision_valid), .accept(accept),
      .match_type(match_type));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reflected CRC form; index bits come out reversed from the low end
   function automatic logic [5:0] ref_hash(input logic [47:0] a);
      logic [31:0] r = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         logic [7:0] d = a[47-8*b -: 8];
         for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB8_8320;
         end
      end
      return {r[0], r[1], r[2], r[3], r[4], r[5]};
   endfunction

   function automatic logic [2:0] ref_type(input logic [47:0] a);
      if (en_ucast && a == station_addr) return 3'd1;
      if (a == 48'hFFFF_FFFF_FFFF) return en_bcast ? 3'd2 : 3'd0;
      if (a[40]) begin
         if (en_mcall) return 3'd3;
         if (en_mchash && hash_table[ref_hash(a)]) return 3'd4;
      end
      return 3'd0;
   endfunction

   task automatic put(input logic [7:0] d, input logic s);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_sof   = s;
      byte_data  = d;
   endtask

   task automatic idle();
      @(negedge clk);
      byte_valid = 1'b0;
      byte_sof   = 1'b0;
   endtask

   // sends a destination field, checks the decision when it is due
   task automatic frame(input logic [47:0] a, input string req);
      logic [2:0] e;
      for (int b = 0; b < 6; b++) begin
         put(a[47-8*b -: 8], b == 0);
         if (b == 5) check({req, " R8 pending"}, decision_valid, 0);
      end
      e = ref_type(a);
      idle();
      check({req, " R6 valid"}, decision_valid, 1);
      check({req, " type"}, match_type, e);
      check({req, " R5 accept"}, accept, e != 3'd0);
   endtask

   task automatic set_en(input logic u, input logic b, input logic m, input logic h);
      en_ucast = u; en_bcast = b; en_mcall = m; en_mchash = h;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual %0d expected below 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] mc, a;
      logic [2:0]  held;
      void'($urandom(32'd20240611));
      station_addr = 48'h0250_C2A1_3377;
      repeat (3) @(negedge clk);
      check("R9 valid", decision_valid, 0);
      check("R9 accept", accept, 0);
      check("R9 type", match_type, 0);
      rst_n = 1'b1;

      // bytes with no frame open are ignored (R8)
      for (int b = 0; b < 8; b++) put(8'hA0 + 8'(b), 1'b0);
      idle(); idle();
      check("R8 out-of-frame", decision_valid, 0);

      set_en(1, 0, 0, 0);
      frame(station_addr, "R1 station match");
      frame(station_addr ^ 48'h1, "R1 last byte differs");
      frame(station_addr ^ 48'h0100_0000_0000, "R1 first byte differs");
      set_en(0, 1, 1, 1);
      hash_table = '1;
      frame(station_addr, "R1 disabled");

      set_en(0, 1, 1, 0);
      frame(48'hFFFF_FFFF_FFFF, "R2 broadcast on");
      set_en(0, 0, 1, 1);
      frame(48'hFFFF_FFFF_FFFF, "R2 broadcast off");

      mc = 48'h0100_5E12_3456;
      frame(mc, "R3 all multicast");
      set_en(0, 0, 0, 0);
      frame(mc, "R5 nothing enabled");

      set_en(0, 0, 0, 1);
      hash_table = 64'h0;
      hash_table[ref_hash(mc)] = 1'b1;
      frame(mc, "R4 hash hit");
      hash_table = ~hash_table;
      frame(mc, "R4 hash miss");
      frame(48'h0200_5E12_3456, "R4 unicast not hashed");

      // R7: trailing bytes leave the decision alone
      set_en(1, 0, 0, 0);
      frame(station_addr, "R7 setup");
      held = match_type;
      for (int b = 0; b < 10; b++) put(8'(b * 7), 1'b0);
      idle();
      check("R7 held valid", decision_valid, 1);
      check("R7 held type", match_type, held);

      // R8: new frame cuts into an unfinished one
      put(8'hFF, 1'b1); put(8'hFF, 1'b0); put(8'hFF, 1'b0);
      frame(station_addr, "R8 restart");

      // constrained random frames
      for (int n = 0; n < 400; n++) begin
         logic [31:0] sel = $urandom % 5;
         set_en($urandom % 2 == 0, $urandom % 2 == 0, $urandom % 4 == 0, $urandom % 2 == 0);
         hash_table = {$urandom, $urandom};
         a = {16'($urandom), $urandom};
         case (sel)
            0: a = station_addr;
            1: a = station_addr ^ (48'h1 << ($urandom % 48));
            2: a = 48'hFFFF_FFFF_FFFF;
            3: a[40] = 1'b1;
            default: a[40] = 1'b0;
         endcase
         frame(a, "R4 random");
      end

      idle();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule